// File: doc/BRIEF.md
# Automatic Volume Leveler

This block levels a stream of signed stereo samples toward one fixed loudness. It follows the peak of the louder channel and steers a multiplicative gain. The aim is that, for any steady input between about −24 dB and 0 dB of full scale, the output settles near −18 dB of full scale. A value of 0 dB means full scale.

The gain falls fast when the input jumps up, so a loud burst is pulled down within a few tens of samples. It rises slowly when the material turns quiet, so the loop does not hunt. A two-bit code picks the recovery speed, from very slow to fast.

When the block is disabled, samples pass through unchanged and the gain is held at unity. The current gain is always visible on an output port. Samples arrive with a one-cycle valid strobe, and each result appears one clock later.

Top module: `avl_leveler`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `gain` is 16384 (unity in the Q2.14 gain format), `out_valid` is 0 and both outputs are 0.
- R2: A sample accepted while `enable` is 0 comes out unchanged on the next cycle, and `gain` reads 16384 after any cycle with `enable` at 0.
- R3: The sample accepted at one clock edge appears at the following edge, with `out_valid` high for exactly that one cycle. Each output equals floor(x·g / 2^14), where g is the `gain` value shown before that sample, and the result is then saturated.
- R4: Outputs saturate to 32767 and −32768 instead of wrapping.
- R5: `gain` always stays within 2063 (about −18 dB) and 32768 (+6 dB).
- R6: The loop compares a level, floor(E·g / 2^14), against the target 4125, where E is the envelope from R8. If the level is above the target, the new gain is max(g − max(g>>4, 1), 2063).
- R7: If the level is below the target, the new gain is min(g + max(g>>s, 1), 32768). The shift s follows `decay_sel`: code 0 gives 14 (slowest), code 1 gives 13, code 2 gives 12 and code 3 gives 6 (fastest). A level equal to the target leaves the gain unchanged.
- R8: The envelope E is the larger of the two channel magnitudes when that exceeds the decayed envelope. Otherwise E is the decayed envelope, which is the previous envelope minus one sixteenth of it (shift by 4). Either channel alone can therefore trigger a cut.
- R9: A steady input of magnitude 2063 to 32767, on either or both channels, drives the output magnitude into the band 3700 to 4260.
- R10: A steady input below 2063 drives the gain to 32768, so the output is twice the input.
- R11: In a cycle with `in_valid` low, the gain and outputs hold their values and `out_valid` is 0.
- R12: After `enable` returns to 1, the gain starts from unity and the first sample passes at unity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | 1 = level the samples, 0 = bypass at unity gain |
| decay_sel | input | 2 | Recovery speed code, 0 slowest to 3 fastest |
| in_valid | input | 1 | Sample strobe |
| in_left | input | SAMPLE_W | Left sample, signed |
| in_right | input | SAMPLE_W | Right sample, signed |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_left | output | SAMPLE_W | Leveled left sample, signed |
| out_right | output | SAMPLE_W | Leveled right sample, signed |
| gain | output | GAIN_W | Current gain, unsigned Q2.14 |

## Verification
The hardest states to reach from the ports are the two ends of the gain range, and what happens just after each. Saturation only shows when a loud sample arrives while the gain is still at its +6 dB ceiling. The stimulus therefore parks the gain at the ceiling with a long run of silence at the fastest recovery code, then fires one near-full-scale pair. The floor is reached exactly with a long full-scale run. A single silent sample after that run must lift the gain at once, which proves that the envelope decays rather than holding its peak.

// File: rtl/avl_pkg.sv
package avl_pkg;

  typedef enum logic [1:0] {
    GA_HOLD  = 2'd0,
    GA_CUT   = 2'd1,
    GA_RAISE = 2'd2
  } gain_step_e;

  // Gain change for one sample: the gain shifted right, but never less than one LSB.
  function automatic int unsigned step_of(input int unsigned g, input int unsigned sh);
    int unsigned s;
    s = g >> sh;
    return (s == 32'd0) ? 32'd1 : s;
  endfunction

endpackage

// File: rtl/avl_envelope.sv
module avl_envelope #(
  parameter int unsigned SAMPLE_W  = 16,
  parameter int unsigned ENV_SHIFT = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic signed [SAMPLE_W-1:0] in_left,
  input  logic signed [SAMPLE_W-1:0] in_right,
  output logic        [SAMPLE_W-1:0] env_next
);

  localparam logic [SAMPLE_W-1:0] ONE = SAMPLE_W'(1);

  function automatic logic [SAMPLE_W-1:0] magnitude(input logic [SAMPLE_W-1:0] s);
    return s[SAMPLE_W-1] ? (~s + ONE) : s;
  endfunction

  logic [SAMPLE_W-1:0] env_q;
  logic [SAMPLE_W-1:0] env_dec;
  logic [SAMPLE_W-1:0] mag_l;
  logic [SAMPLE_W-1:0] mag_r;
  logic [SAMPLE_W-1:0] peak;

  always_comb begin
    mag_l    = magnitude(in_left);
    mag_r    = magnitude(in_right);
    peak     = (mag_l > mag_r) ? mag_l : mag_r;
    env_dec  = env_q - (env_q >> ENV_SHIFT);
    env_next = (peak > env_dec) ? peak : env_dec;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        env_q <= '0;
    else if (in_valid) env_q <= env_next;
  end

endmodule

// File: rtl/avl_gain_ctrl.sv
module avl_gain_ctrl
  import avl_pkg::*;
#(
  parameter int unsigned SAMPLE_W     = 16,
  parameter int unsigned GAIN_W       = 16,
  parameter int unsigned GAIN_FRAC    = 14,
  parameter int unsigned TARGET_LEVEL = 4125,
  parameter int unsigned GAIN_MIN     = 2063,
  parameter int unsigned GAIN_MAX     = 32768,
  parameter int unsigned ATTACK_SHIFT = 4,
  parameter int unsigned REL_SH0      = 14,
  parameter int unsigned REL_SH1      = 13,
  parameter int unsigned REL_SH2      = 12,
  parameter int unsigned REL_SH3      = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic                in_valid,
  input  logic [1:0]          decay_sel,
  input  logic [SAMPLE_W-1:0] env_next,
  output logic [GAIN_W-1:0]   gain_q,
  output logic                attack_evt,
  output logic                release_evt
);

  localparam int unsigned LW = SAMPLE_W + GAIN_W;
  localparam logic [LW-1:0] TARGET_L = LW'(TARGET_LEVEL);
  localparam logic [GAIN_W-1:0] UNITY = GAIN_W'(32'd1 << GAIN_FRAC);
  localparam int unsigned REL_TABLE [4] = '{REL_SH0, REL_SH1, REL_SH2, REL_SH3};

  logic [LW-1:0]     level;
  int unsigned       g_i;
  int unsigned       rel_sh;
  int unsigned       cut_i;
  int unsigned       raise_i;
  gain_step_e        step_kind;
  logic [GAIN_W-1:0] gain_cut;
  logic [GAIN_W-1:0] gain_raise;

  always_comb begin
    level   = (LW'(env_next) * LW'(gain_q)) >> GAIN_FRAC;
    g_i     = 32'(gain_q);
    rel_sh  = REL_TABLE[decay_sel];
    cut_i   = g_i - step_of(g_i, ATTACK_SHIFT);
    if (cut_i < GAIN_MIN) cut_i = GAIN_MIN;
    raise_i = g_i + step_of(g_i, rel_sh);
    if (raise_i > GAIN_MAX) raise_i = GAIN_MAX;
    gain_cut   = GAIN_W'(cut_i);
    gain_raise = GAIN_W'(raise_i);

    attack_evt  = enable && in_valid && (level > TARGET_L);
    release_evt = enable && in_valid && (level < TARGET_L);
    if (attack_evt)       step_kind = GA_CUT;
    else if (release_evt) step_kind = GA_RAISE;
    else                  step_kind = GA_HOLD;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      gain_q <= UNITY;
    end else begin
      case (step_kind)
        GA_CUT:   gain_q <= gain_cut;
        GA_RAISE: gain_q <= gain_raise;
        default:  gain_q <= gain_q;
      endcase
    end
  end

endmodule

// File: rtl/avl_apply.sv
module avl_apply #(
  parameter int unsigned SAMPLE_W  = 16,
  parameter int unsigned GAIN_W    = 16,
  parameter int unsigned GAIN_FRAC = 14
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       enable,
  input  logic                       in_valid,
  input  logic signed [SAMPLE_W-1:0] in_left,
  input  logic signed [SAMPLE_W-1:0] in_right,
  input  logic        [GAIN_W-1:0]   gain_q,
  output logic                       out_valid,
  output logic signed [SAMPLE_W-1:0] out_left,
  output logic signed [SAMPLE_W-1:0] out_right
);

  localparam int unsigned NCH = 2;
  localparam int unsigned PW  = SAMPLE_W + GAIN_W + 1;
  localparam logic signed [PW-1:0] SMAX = PW'((longint'(1) <<< (SAMPLE_W - 1)) - 1);
  localparam logic signed [PW-1:0] SMIN = PW'(-(longint'(1) <<< (SAMPLE_W - 1)));

  function automatic logic signed [SAMPLE_W-1:0] scale_sat(
    input logic signed [SAMPLE_W-1:0] x,
    input logic        [GAIN_W-1:0]   g
  );
    logic signed [PW-1:0] p;
    p = PW'(x) * PW'($signed({1'b0, g}));
    p = p >>> GAIN_FRAC;
    if (p > SMAX)      return SMAX[SAMPLE_W-1:0];
    else if (p < SMIN) return SMIN[SAMPLE_W-1:0];
    else               return p[SAMPLE_W-1:0];
  endfunction

  logic signed [SAMPLE_W-1:0] ch_in  [NCH];
  logic signed [SAMPLE_W-1:0] ch_out [NCH];

  assign ch_in[0] = in_left;
  assign ch_in[1] = in_right;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    always_ff @(posedge clk) begin
      if (!rst_n)        ch_out[c] <= '0;
      else if (in_valid) ch_out[c] <= enable ? scale_sat(ch_in[c], gain_q) : ch_in[c];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= in_valid;
  end

  assign out_left  = ch_out[0];
  assign out_right = ch_out[1];

endmodule

// File: rtl/avl_leveler.sv
module avl_leveler #(
  parameter int unsigned SAMPLE_W       = 16,
  parameter int unsigned GAIN_W         = 16,
  parameter int unsigned GAIN_FRAC      = 14,
  parameter int unsigned TARGET_LEVEL   = 4125,
  parameter int unsigned GAIN_MIN       = 2063,
  parameter int unsigned GAIN_MAX       = 32768,
  parameter int unsigned ATTACK_SHIFT   = 4,
  parameter int unsigned ENV_SHIFT      = 4,
  parameter int unsigned REL_SHIFT_C0   = 14,
  parameter int unsigned REL_SHIFT_C1   = 13,
  parameter int unsigned REL_SHIFT_C2   = 12,
  parameter int unsigned REL_SHIFT_C3   = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       enable,
  input  logic [1:0]                 decay_sel,
  input  logic                       in_valid,
  input  logic signed [SAMPLE_W-1:0] in_left,
  input  logic signed [SAMPLE_W-1:0] in_right,
  output logic                       out_valid,
  output logic signed [SAMPLE_W-1:0] out_left,
  output logic signed [SAMPLE_W-1:0] out_right,
  output logic        [GAIN_W-1:0]   gain
);

  logic [SAMPLE_W-1:0] env_next;
  logic [GAIN_W-1:0]   gain_q;
  logic                attack_evt;
  logic                release_evt;

  avl_envelope #(
    .SAMPLE_W (SAMPLE_W),
    .ENV_SHIFT(ENV_SHIFT)
  ) u_env (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_left  (in_left),
    .in_right (in_right),
    .env_next (env_next)
  );

  avl_gain_ctrl #(
    .SAMPLE_W    (SAMPLE_W),
    .GAIN_W      (GAIN_W),
    .GAIN_FRAC   (GAIN_FRAC),
    .TARGET_LEVEL(TARGET_LEVEL),
    .GAIN_MIN    (GAIN_MIN),
    .GAIN_MAX    (GAIN_MAX),
    .ATTACK_SHIFT(ATTACK_SHIFT),
    .REL_SH0     (REL_SHIFT_C0),
    .REL_SH1     (REL_SHIFT_C1),
    .REL_SH2     (REL_SHIFT_C2),
    .REL_SH3     (REL_SHIFT_C3)
  ) u_gain (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .in_valid   (in_valid),
    .decay_sel  (decay_sel),
    .env_next   (env_next),
    .gain_q     (gain_q),
    .attack_evt (attack_evt),
    .release_evt(release_evt)
  );

  avl_apply #(
    .SAMPLE_W (SAMPLE_W),
    .GAIN_W   (GAIN_W),
    .GAIN_FRAC(GAIN_FRAC)
  ) u_apply (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .in_valid (in_valid),
    .in_left  (in_left),
    .in_right (in_right),
    .gain_q   (gain_q),
    .out_valid(out_valid),
    .out_left (out_left),
    .out_right(out_right)
  );

  assign gain = gain_q;

endmodule

// File: rtl/avl_leveler_chk.sv
module avl_leveler_chk #(
  parameter int unsigned SAMPLE_W = 16,
  parameter int unsigned GAIN_W   = 16,
  parameter int unsigned GMIN     = 2063,
  parameter int unsigned GMAX     = 32768,
  parameter int unsigned UNITY    = 16384
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       enable,
  input logic                       in_valid,
  input logic signed [SAMPLE_W-1:0] in_left,
  input logic signed [SAMPLE_W-1:0] in_right,
  input logic                       out_valid,
  input logic signed [SAMPLE_W-1:0] out_left,
  input logic signed [SAMPLE_W-1:0] out_right,
  input logic        [GAIN_W-1:0]   gain,
  input logic                       attack_evt,
  input logic                       release_evt
);

  assert_gain_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (gain >= GAIN_W'(GMIN)) && (gain <= GAIN_W'(GMAX)));

  assert_bypass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !enable) |=> (out_left == $past(in_left)) && (out_right == $past(in_right)));

  assert_unity_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (gain == GAIN_W'(UNITY)));

  assert_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(out_left) && $stable(out_right));

  assert_idle_gain_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !in_valid) |=> $stable(gain));

  assert_cut_R6: assert property (@(posedge clk) disable iff (!rst_n)
    attack_evt |=> (gain < $past(gain)) || (gain == GAIN_W'(GMIN)));

  assert_raise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    release_evt |=> (gain > $past(gain)) || (gain == GAIN_W'(GMAX)));

endmodule

bind avl_leveler avl_leveler_chk #(
  .SAMPLE_W(SAMPLE_W),
  .GAIN_W  (GAIN_W),
  .GMIN    (GAIN_MIN),
  .GMAX    (GAIN_MAX),
  .UNITY   (32'd1 << GAIN_FRAC)
) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .enable     (enable),
  .in_valid   (in_valid),
  .in_left    (in_left),
  .in_right   (in_right),
  .out_valid  (out_valid),
  .out_left   (out_left),
  .out_right  (out_right),
  .gain       (gain),
  .attack_evt (attack_evt),
  .release_evt(release_evt)
);

// File: tb/test_avl_leveler.sv
module test_avl_leveler;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               enable = 1'b0;
  logic [1:0]         decay_sel = 2'd3;
  logic               in_valid = 1'b0;
  logic signed [15:0] in_left = '0;
  logic signed [15:0] in_right = '0;
  logic               out_valid;
  logic signed [15:0] out_left;
  logic signed [15:0] out_right;
  logic [15:0]        gain;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  avl_leveler i_avl_leveler (
    .clk(clk), .rst_n(rst_n), .enable(enable), .decay_sel(decay_sel),
    .in_valid(in_valid), .in_left(in_left), .in_right(in_right),
    .out_valid(out_valid), .out_left(out_left), .out_right(out_right), .gain(gain)
  );

  // Steady-state vectors: left, right, which output to check (0 left, 1 right),
  // output band, gain band, requirement tag number.
  localparam int NV = 6;
  localparam int TV_L   [NV] = '{  8000, 32767, 2063,   500, -16000,     0};
  localparam int TV_R   [NV] = '{  8000, 32767, 2063,   500,      0, 12000};
  localparam int TV_SEL [NV] = '{     0,     0,    0,     0,      0,     1};
  localparam int TV_LO  [NV] = '{  3700,  3700, 3700,  1000,  -4260,  3700};
  localparam int TV_HI  [NV] = '{  4260,  4260, 4260,  1000,  -3700,  4260};
  localparam int TV_GLO [NV] = '{  7700,  2063, 30000, 32768,  3850,  5100};
  localparam int TV_GHI [NV] = '{  8800,  2200, 32768, 32768,  4400,  5900};
  localparam int TV_TAG [NV] = '{     9,     9,    9,    10,      9,     8};

  localparam int REL_SH [4] = '{14, 13, 12, 6};

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_range(input string tag, input longint act, input longint lo, input longint hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
    end
  endtask

  task automatic send(input int l, input int r);
    @(negedge clk);
    in_valid = 1'b1;
    in_left  = 16'(l);
    in_right = 16'(r);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic longint exp_scaled(input longint x, input longint g);
    longint p;
    p = (x * g) >>> 14;
    if (p > 32767)  p = 32767;
    if (p < -32768) p = -32768;
    return p;
  endfunction

  function automatic longint exp_cut(input longint g);
    longint s, n;
    s = g / 16; if (s == 0) s = 1;
    n = g - s;
    return (n < 2063) ? 2063 : n;
  endfunction

  function automatic longint exp_raise(input longint g, input int sh);
    longint s, n;
    s = g / (longint'(1) << sh); if (s == 0) s = 1;
    n = g + s;
    return (n > 32768) ? 32768 : n;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    longint g;
    repeat (4) @(negedge clk);
    check(gain == 16'd16384, "R1 gain in reset", gain, 16384);
    rst_n = 1'b1;
    check(gain == 16'd16384, "R1 gain after reset", gain, 16384);
    check(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    check(out_left == 0 && out_right == 0, "R1 outputs", out_left, 0);

    // R6: cut steps from unity on a loud left sample
    enable = 1'b1; decay_sel = 2'd3;
    send(20000, 0);
    check(out_valid == 1'b1, "R3 out_valid pulse", out_valid, 1);
    check(out_left == 16'sd20000, "R3 unity output", out_left, 20000);
    check(gain == 16'd15360, "R6 first cut", gain, 15360);
    send(20000, 0);
    check(out_left == 16'sd18750, "R3 output with reduced gain", out_left, 18750);
    check(gain == 16'd14400, "R6 second cut", gain, 14400);

    // Steady-state table (R8, R9, R10)
    for (int i = 0; i < NV; i++) begin
      for (int k = 0; k < 600; k++) send(TV_L[i], TV_R[i]);
      check_range((TV_TAG[i] == 10) ? "R10 output" : (TV_TAG[i] == 8) ? "R8 right-only output" : "R9 output",
                  (TV_SEL[i] == 1) ? longint'(out_right) : longint'(out_left), TV_LO[i], TV_HI[i]);
      check_range((TV_TAG[i] == 10) ? "R10 gain" : (TV_TAG[i] == 8) ? "R8 right-only gain" : "R9 gain",
                  longint'(gain), TV_GLO[i], TV_GHI[i]);
    end

    // Gain floor, then envelope decay lifts the gain at once
    decay_sel = 2'd3;
    for (int k = 0; k < 300; k++) send(32767, 32767);
    check(gain == 16'd2063, "R5 gain floor", gain, 2063);
    send(0, 0);
    check(gain == 16'd2095, "R8 envelope decays after peak", gain, 2095);

    // R7: one quiet sample per recovery code
    for (int c = 0; c < 4; c++) begin
      decay_sel = 2'(c);
      g = longint'(gain);
      send(0, 0);
      check(longint'(gain) == exp_raise(g, REL_SH[c]), "R7 recovery step", gain, exp_raise(g, REL_SH[c]));
    end

    // Gain ceiling, then saturation on a loud pair
    decay_sel = 2'd3;
    for (int k = 0; k < 400; k++) send(0, 0);
    check(gain == 16'd32768, "R10 gain ceiling", gain, 32768);
    send(30000, -30000);
    check(out_left == 16'sd32767, "R4 positive saturation", out_left, 32767);
    check(out_right == -16'sd32768, "R4 negative saturation", out_right, -32768);

    // R3: exact product with floor rounding
    g = longint'(gain);
    send(-12345, 777);
    check(longint'(out_left) == exp_scaled(-12345, g), "R3 left product", out_left, exp_scaled(-12345, g));
    check(longint'(out_right) == exp_scaled(777, g), "R3 right product", out_right, exp_scaled(777, g));

    // R11: idle cycles change nothing
    g = longint'(gain);
    begin
      logic signed [15:0] ol;
      ol = out_left;
      repeat (5) @(negedge clk);
      check(longint'(gain) == g, "R11 gain held", gain, g);
      check(out_left == ol, "R11 output held", out_left, ol);
      check(out_valid == 1'b0, "R11 no strobe", out_valid, 0);
    end

    // R2: bypass
    enable = 1'b0;
    send(-1234, 5678);
    check(out_left == -16'sd1234 && out_right == 16'sd5678, "R2 bypass", out_left, -1234);
    check(gain == 16'd16384, "R2 unity gain", gain, 16384);
    send(32767, -32768);
    check(out_left == 16'sd32767 && out_right == -16'sd32768, "R2 bypass full scale", out_right, -32768);

    // R12: re-enable from unity
    enable = 1'b1;
    repeat (3) @(negedge clk);
    check(gain == 16'd16384, "R12 unity on enable", gain, 16384);
    send(1000, -1000);
    check(out_left == 16'sd1000 && out_right == -16'sd1000, "R12 first sample at unity", out_left, 1000);

    // R8: the right channel alone triggers a cut
    decay_sel = 2'd0;
    for (int k = 0; k < 100; k++) send(0, 0);
    g = longint'(gain);
    send(0, 20000);
    check(longint'(gain) == exp_cut(g), "R8 right channel cut", gain, exp_cut(g));
    check(longint'(out_right) == exp_scaled(20000, g), "R3 right output", out_right, exp_scaled(20000, g));
    check(out_left == 0, "R3 silent left", out_left, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

endmodule